// File: doc/BRIEF.md
# Chip-Addressed Serial Register Slave

This block is the serial-port slave of a device that holds a bank of 8-bit configuration registers. A host reaches it over four wires: an active-low select, a serial clock, a data-in line and a data-out line. Two strap inputs give the device a chip address, so up to four devices can share one bus. All serial pins are brought into the block's own clock domain through synchronizers, and the serial clock edges are found there. For this reason the system clock must run several times faster than the serial clock.

A frame opens with a direction bit and continues with a 15-bit address. The two top address bits name the target chip, except when the top four bits carry the broadcast tag. A broadcast write lands on every device, whatever its straps say. After the address, a write sends data bytes, and each further byte goes to the next register for as long as select stays low. A read returns one byte on the data-out line. The register bank has a power-of-two size, set by a parameter. Only the low address bits index it, and the write pointer wraps at the top of the bank.

Top module: `spi_regbank`

## Requirements
- R1: Bits on `sdi` are taken at rising serial-clock edges. The order is: a direction bit (1 = read, 0 = write), then address bits A14 down to A0, then data bits D7 down to D0.
- R2: A write frame whose address bits A14:A13 equal `strap` and whose A14:A11 differ from 0001 stores its first data byte in the register indexed by the low `IDX_W` address bits.
- R3: In a matching read, `sdo_en` is high and `sdo` carries the register's 8 bits MSB first. Each bit changes on a falling serial-clock edge, starting with the falling edge right after address bit A0. `sdo_en` stays low during the header of any frame and during every write frame.
- R4: In a write frame, every further complete byte sent while select stays low goes to the next register index, with no limit on the byte count. The index wraps from `2**IDX_W-1` to 0.
- R5: A write whose A14:A11 equal 0001 is accepted whatever the value of `strap`.
- R6: A frame whose A14:A13 differ from `strap` and which is not a broadcast write changes no register, and in a read `sdo_en` and `sdo` stay low.
- R7: A read whose A14:A11 equal 0001 produces no output: `sdo_en` and `sdo` stay low, even when the chip bits match `strap`.
- R8: If select rises before the eighth bit of a data byte, that partial byte is dropped and no register changes. Bytes completed earlier in the frame remain written.
- R9: After reset every register reads 0. While select is high, `sdo_en` and `sdo` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| strap | input | 2 | Chip-address strap pins |
| sdo | output | 1 | Serial data out, held low when not driving |
| sdo_en | output | 1 | High while the block is driving read data |

## Verification
Some behaviour is checked by assertions on every cycle. Read output must go quiet one cycle after the synchronized select goes high. A broadcast frame must never drive data out. Two writes must never land on adjacent cycles, and the write index must advance by exactly one, modulo the bank size, after every write. Other behaviour only the bench scenarios can show, by comparing a behavioural register model with read-back bit streams at each host sampling point. These scenarios cover bit ordering, strap matching and mismatching, the broadcast write and read cases, pointer wrap across the top of the bank, and dropping a partial trailing byte.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;

  localparam int HDR_BITS  = 16;
  localparam int BYTE_BITS = 8;
  localparam logic [3:0] BCAST_TAG = 4'b0001;

endpackage

// File: rtl/spi_regbank_sync.sv
module spi_regbank_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= RST_VAL;
          else        stg_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/spi_regbank_regs.sv
module spi_regbank_regs #(
  parameter int IDX_W = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);

  localparam int NUM_REGS = 1 << IDX_W;

  logic [DW-1:0] mem_q [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/spi_regbank_frame.sv
module spi_regbank_frame
  import spi_regbank_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             sdi,
  input  logic [1:0]       strap,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sdo_bit,
  output logic             sdo_en
);

  localparam int CNT_W = $clog2(HDR_BITS);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_BITS - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [14:0]      hdr_q, hdr_d;
  logic [6:0]       dat_q, dat_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       rsh_q, rsh_d;
  logic             sdo_q, sdo_d;
  logic             bc_q, bc_d;

  logic [15:0] hdr_full;
  logic        f_rw, f_bc, f_match;
  logic [14:0] f_addr;

  always_comb begin
    hdr_full = {hdr_q, sdi};
    f_rw     = hdr_full[15];
    f_addr   = hdr_full[14:0];
    f_bc     = (f_addr[14:11] == BCAST_TAG);
    f_match  = (f_addr[14:13] == strap);
  end

  assign rd_idx = f_addr[IDX_W-1:0];

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    hdr_d   = hdr_q;
    dat_d   = dat_q;
    idx_d   = idx_q;
    rsh_d   = rsh_q;
    sdo_d   = sdo_q;
    bc_d    = bc_q;
    wr_en   = 1'b0;
    wr_data = {dat_q, sdi};
    if (!cs_act) begin
      phase_d = PH_HDR;
      cnt_d   = '0;
      sdo_d   = 1'b0;
    end else begin
      unique case (phase_q)
        PH_HDR: if (sclk_rise) begin
          hdr_d = hdr_full[14:0];
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == HDR_LAST) begin
            cnt_d = '0;
            idx_d = f_addr[IDX_W-1:0];
            bc_d  = f_bc;
            rsh_d = rd_data;
            sdo_d = 1'b0;
            if (f_rw) phase_d = (f_match && !f_bc) ? PH_RD : PH_SKIP;
            else      phase_d = (f_match || f_bc)  ? PH_WR : PH_SKIP;
          end
        end
        PH_WR: if (sclk_rise) begin
          dat_d = {dat_q[5:0], sdi};
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == BYTE_LAST) begin
            cnt_d = '0;
            wr_en = 1'b1;
            idx_d = idx_q + IDX_W'(1);
          end
        end
        PH_RD: begin
          if (sclk_fall) begin
            sdo_d = rsh_q[7];
            rsh_d = {rsh_q[6:0], 1'b0};
          end
          if (sclk_rise) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q == BYTE_LAST) phase_d = PH_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HDR;
      cnt_q   <= '0;
      hdr_q   <= '0;
      dat_q   <= '0;
      idx_q   <= '0;
      rsh_q   <= '0;
      sdo_q   <= 1'b0;
      bc_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      hdr_q   <= hdr_d;
      dat_q   <= dat_d;
      idx_q   <= idx_d;
      rsh_q   <= rsh_d;
      sdo_q   <= sdo_d;
      bc_q    <= bc_d;
    end
  end

  assign wr_idx  = idx_q;
  assign sdo_bit = sdo_q;
  assign sdo_en  = (phase_q == PH_RD);

  AST_BCAST_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> !bc_q); // R7
  AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R4
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (idx_q == $past(idx_q) + IDX_W'(1))); // R4

endmodule

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int IDX_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  input  logic [1:0] strap,
  output logic       sdo,
  output logic       sdo_en
);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_i;
  logic [2:0]       pins_s;
  logic             cs_s, sclk_s, sdi_s;
  logic             sclk_last_q;
  logic             sclk_rise, sclk_fall;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [7:0]       rd_data, wr_data;
  logic             wr_en, sdo_bit, sdo_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  spi_regbank_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst_n(rst_n_i),
    .din({cs_n, sclk, sdi}), .dout(pins_s)
  );
  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sclk_last_q <= 1'b0;
    else          sclk_last_q <= sclk_s;
  end
  assign sclk_rise = sclk_s & ~sclk_last_q;
  assign sclk_fall = ~sclk_s & sclk_last_q;

  spi_regbank_frame #(.IDX_W(IDX_W)) u_frame (
    .clk(clk), .rst_n(rst_n_i), .cs_act(~cs_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi(sdi_s),
    .strap(strap), .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sdo_bit(sdo_bit), .sdo_en(sdo_en_i)
  );

  spi_regbank_regs #(.IDX_W(IDX_W), .DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign sdo_en = sdo_en_i;
  assign sdo    = sdo_bit & sdo_en_i;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_i)
    $past(cs_s) |-> !sdo_en); // R9
  AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n_i)
    $past(cs_s) |-> !wr_en); // R8

endmodule

// File: tb/spi_regbank_test.sv
`timescale 1ns/1ps
module spi_regbank_test;

  localparam int HALF = 8;
  localparam int NREG = 16;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sclk, sdi;
  logic [1:0] strap;
  wire        sdo, sdo_en;

  int checks = 0;
  int fails  = 0;
  int idle_cnt = 0;
  bit done = 0;
  int exp_regs [NREG];
  logic [7:0] tx_q [$];

  always #2.5 clk = ~clk;

  spi_regbank uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .strap(strap), .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  // R9: output must be quiet while select has been high for a while
  always @(negedge clk) begin
    if (!done) begin
      if (cs_n === 1'b1) idle_cnt++;
      else               idle_cnt = 0;
      if (idle_cnt >= 6) begin
        check_eq("R9", "idle sdo_en", int'(sdo_en), 0);
        check_eq("R9", "idle sdo", int'(sdo), 0);
      end
    end
  end

  task automatic put_bit(bit b, output bit so, output bit soe);
    sdi = b;
    clocks(HALF);
    so  = sdo;
    soe = sdo_en;
    sclk = 1'b1;
    clocks(HALF);
    sclk = 1'b0;
  endtask

  task automatic frame(bit rw, logic [14:0] a, int tail_bits, string req);
    bit so, soe;
    logic [15:0] hdr = {rw, a};
    bit bc     = (a[14:11] == 4'b0001);
    bit match  = (a[14:13] == strap);
    bit rd_hit = rw && match && !bc;
    bit wr_hit = !rw && (bc || match);
    int idx    = int'(a[3:0]);
    cs_n = 1'b0;
    clocks(4);
    for (int i = 0; i < 16; i++) begin
      put_bit(hdr[15-i], so, soe);
      check_eq("R3", "sdo_en in header", int'(soe), 0);
    end
    if (rw) begin
      for (int k = 0; k < 8; k++) begin
        put_bit(k[0], so, soe);
        if (rd_hit) begin
          check_eq(req, "read sdo_en", int'(soe), 1);
          check_eq(req, $sformatf("read bit D%0d of reg %0d", 7-k, idx),
                   int'(so), (exp_regs[idx] >> (7-k)) & 1);
        end else begin
          check_eq(req, "silent sdo_en", int'(soe), 0);
          check_eq(req, "silent sdo", int'(so), 0);
        end
      end
    end else begin
      for (int j = 0; j < tx_q.size(); j++) begin
        logic [7:0] d = tx_q[j];
        for (int k = 0; k < 8; k++) put_bit(d[7-k], so, soe);
        check_eq("R3", "sdo_en during write", int'(soe), 0);
        if (wr_hit) exp_regs[(idx + j) % NREG] = int'(d);
      end
    end
    for (int t = 0; t < tail_bits; t++) put_bit(1'b1, so, soe);
    clocks(2);
    cs_n = 1'b1;
    clocks(10);
    tx_q.delete();
  endtask

  task automatic rd(logic [14:0] a, string req);
    frame(1'b1, a, 0, req);
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) exp_regs[i] = 0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; strap = 2'b10;
    clocks(5);
    rst_n = 1'b1;
    clocks(8);

    // R9: reset value
    rd(15'h4003, "R9");
    // R2, R3: single write then read back
    tx_q.push_back(8'h3C);
    frame(1'b0, 15'h4005, 0, "R2");
    rd(15'h4005, "R2");
    // R4: block write crossing the top of the bank
    tx_q.push_back(8'hA1); tx_q.push_back(8'hB2);
    tx_q.push_back(8'hC3); tx_q.push_back(8'hD4);
    frame(1'b0, 15'h400E, 0, "R4");
    rd(15'h400E, "R4"); rd(15'h400F, "R4");
    rd(15'h4000, "R4"); rd(15'h4001, "R4");
    // R5: broadcast write under two strap values
    tx_q.push_back(8'h5A);
    frame(1'b0, 15'h0807, 0, "R5");
    rd(15'h4007, "R5");
    strap = 2'b11;
    tx_q.push_back(8'h66);
    frame(1'b0, 15'h0808, 0, "R5");
    rd(15'h6008, "R5");
    // R6: wrong chip address
    strap = 2'b10;
    tx_q.push_back(8'hFF);
    frame(1'b0, 15'h2005, 0, "R6");
    rd(15'h4005, "R6");
    rd(15'h2005, "R6");
    // R7 and R1 with chip address 0
    strap = 2'b00;
    rd(15'h0805, "R7");
    tx_q.push_back(8'h81);
    frame(1'b0, 15'h0009, 0, "R1");
    rd(15'h0009, "R1");
    rd(15'h0005, "R1");
    // R8: partial trailing byte dropped
    strap = 2'b10;
    tx_q.push_back(8'h96);
    frame(1'b0, 15'h4002, 5, "R8");
    rd(15'h4002, "R8");
    rd(15'h4003, "R8");
    frame(1'b0, 15'h400B, 3, "R8");
    rd(15'h400B, "R8");

    summary();
    $finish;
  end

endmodule